// File: doc/BRIEF.md
# Serial Shared-Memory Bridge

This block lets an external host processor reach a small shared memory over a four-wire synchronous serial link. The host is always the clock master. It lowers the chip select and clocks in a fixed 24-bit frame. The frame carries a direction bit, a group of filler bits, a byte address and a data byte. For a write frame, the bridge stores the byte. For a read frame, it fetches the addressed byte and shifts it back during the last eight clocks of the frame.

The memory has two ports. A local processor owns the second port and uses it on every cycle without wait states, whatever the serial side is doing. All serial pins are resynchronised into the system clock domain. The bridge acts only on serial clock edges that it detects in that domain. The host's serial clock must therefore be slow compared with the system clock: the bench uses a half period of ten system clocks.

The bridge also drives an attention line toward the host. The local side raises this line with a one-cycle pulse. The host clears it by reading one reserved address. That read returns the line's state instead of memory content.

Top module: `spi_ram_bridge`

## Requirements
- R1: A frame whose first bit is 0 (write) stores its last 8 bits at the frame's address once all 24 bits have been clocked in. The stored byte is then visible through the local read port.
- R2: A frame whose first bit is 1 (read) drives the byte held at its address on the data-out pin, MSB first. The bits cover the 17th through 24th rising serial clock edges, and the host samples data-out at each of those rising edges.
- R3: Frame layout, MSB first, sampled on rising serial clock edges: bit 1 is the command, bits 2 to 6 are filler whose values have no effect, bits 7 to 16 are the 10-bit address (MSB first), and bits 17 to 24 are the data byte.
- R4: If chip select goes high before the 24th rising edge of a write frame, the memory is not modified.
- R5: Rising serial clock edges after the 24th edge, up to the point where chip select goes high, are ignored. The stored byte is not rewritten with the later bits.
- R6: The local port writes on a clock with enable and write both high. On a read, it returns the addressed byte one clock later. This holds while a serial frame is in progress.
- R7: A one-cycle high pulse on `loc_irq_set` sets `host_irq` on the next clock. `host_irq` then stays high until it is cleared.
- R8: A completed host read of address 0x3FF returns a byte with bit 0 equal to the `host_irq` state and all other bits 0. The same read clears `host_irq`.
- R9: After reset, `host_irq` is 0 and `ser_miso` is 0. `ser_miso` also returns to 0 once chip select is high.
- R10: A status read aborted before its last address bit leaves `host_irq` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_sclk | input | 1 | Serial clock from host, idles low |
| ser_cs_n | input | 1 | Active-low frame select from host |
| ser_mosi | input | 1 | Serial data from host |
| ser_miso | output | 1 | Serial data to host |
| host_irq | output | 1 | Attention line to host |
| loc_en | input | 1 | Local port access enable |
| loc_we | input | 1 | Local port write select |
| loc_addr | input | 10 | Local port byte address |
| loc_wdata | input | 8 | Local port write byte |
| loc_rdata | output | 8 | Local port read byte, one clock latency |
| loc_irq_set | input | 1 | Pulse that raises the attention line |

## Verification
The bench builds the bridge with its default values: a 10-bit address, 8-bit data, 5 filler bits, a two-flop synchroniser and the status location enabled at 0x3FF. Because the address space is full width, the vector table can reach both end locations, including 0x3FE, which sits next to the reserved status address. With the status option enabled, the set, clear and aborted-clear behaviour of the attention line can be tested. The filler width makes the header exactly 16 bits, so the tests of filler bits, truncated frames and overlong frames probe the edge-count boundaries at 16 and 24.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
   typedef enum logic {
      CMD_WR = 1'b0,
      CMD_RD = 1'b1
   } br_cmd_e;
endpackage

// File: rtl/br_sync.sv
module br_sync #(
   parameter int          W        = 3,
   parameter int          STAGES   = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("br_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/br_dpram.sv
module br_dpram #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              a_en,
   input  logic              a_we,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [DATA_W-1:0] a_wdata,
   output logic [DATA_W-1:0] a_rdata,
   input  logic              b_en,
   input  logic              b_we,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic [DATA_W-1:0] b_wdata,
   output logic [DATA_W-1:0] b_rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   // Port A (local) is applied last, so it wins a same-address collision.
   always_ff @(posedge clk) begin
      if (b_en) begin
         if (b_we) mem[b_addr] <= b_wdata;
         b_rdata <= mem[b_addr];
      end
      if (a_en) begin
         if (a_we) mem[a_addr] <= a_wdata;
         a_rdata <= mem[a_addr];
      end
   end
endmodule

// File: rtl/br_frame_eng.sv
module br_frame_eng
   import bridge_pkg::*;
#(
   parameter int ADDR_W      = 10,
   parameter int DATA_W      = 8,
   parameter int PAD_W       = 5,
   parameter int STATUS_ADDR = 1023,
   parameter bit HAS_STATUS  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_s,
   input  logic              csn_s,
   input  logic              mosi_s,
   input  logic [DATA_W-1:0] ram_rdata,
   input  logic [DATA_W-1:0] stat_byte,
   output logic              ram_en,
   output logic              ram_we,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [DATA_W-1:0] ram_wdata,
   output logic              stat_clr,
   output logic              miso
);
   localparam int HDR_W     = 1 + PAD_W + ADDR_W;
   localparam int FRAME_LEN = HDR_W + DATA_W;
   localparam int CNT_W     = $clog2(FRAME_LEN + 1);
   localparam logic [CNT_W-1:0] HDR_C   = CNT_W'(HDR_W);
   localparam logic [CNT_W-1:0] HDR_M1  = CNT_W'(HDR_W - 1);
   localparam logic [CNT_W-1:0] FRM_C   = CNT_W'(FRAME_LEN);
   localparam logic [CNT_W-1:0] FRM_M1  = CNT_W'(FRAME_LEN - 1);
   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STATUS_ADDR);

   logic              sclk_q;
   logic [CNT_W-1:0]  cnt;
   logic [HDR_W-2:0]  rx;
   logic [HDR_W-1:0]  rx_next;
   br_cmd_e           cmd_q;
   logic [ADDR_W-1:0] addr_q;
   logic              rd_issue, rd_vld, wr_q;
   logic [DATA_W-1:0] wdat_q;
   logic [DATA_W-1:0] tx;
   logic              rise, fall, active, is_stat;

   assign rise    = sclk_s & ~sclk_q;
   assign fall    = ~sclk_s & sclk_q;
   assign active  = ~csn_s;
   assign rx_next = {rx, mosi_s};

   if (HAS_STATUS) begin : g_stat
      assign is_stat = (addr_q == STAT_A);
   end else begin : g_nostat
      assign is_stat = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q   <= 1'b0;
         cnt      <= '0;
         rx       <= '0;
         cmd_q    <= CMD_WR;
         addr_q   <= '0;
         rd_issue <= 1'b0;
         rd_vld   <= 1'b0;
         wr_q     <= 1'b0;
         wdat_q   <= '0;
         tx       <= '0;
      end else begin
         sclk_q   <= sclk_s;
         rd_issue <= 1'b0;
         wr_q     <= 1'b0;
         rd_vld   <= rd_issue & ~is_stat;
         if (!active) begin
            cnt <= '0;
            tx  <= '0;
         end else begin
            if (rise && cnt < FRM_C) begin
               rx  <= rx_next[HDR_W-2:0];
               cnt <= cnt + 1'b1;
               if (cnt == HDR_M1) begin
                  cmd_q    <= br_cmd_e'(rx_next[HDR_W-1]);
                  addr_q   <= rx_next[ADDR_W-1:0];
                  rd_issue <= rx_next[HDR_W-1];
               end
               if (cnt == FRM_M1 && cmd_q == CMD_WR) begin
                  wr_q   <= 1'b1;
                  wdat_q <= rx_next[DATA_W-1:0];
               end
            end
            if (fall && cnt > HDR_C && cnt < FRM_C) tx <= {tx[DATA_W-2:0], 1'b0};
            if (rd_issue && is_stat) tx <= stat_byte;
            if (rd_vld) tx <= ram_rdata;
         end
      end
   end

   assign ram_en    = rd_issue | wr_q;
   assign ram_we    = wr_q;
   assign ram_addr  = addr_q;
   assign ram_wdata = wdat_q;
   assign stat_clr  = rd_issue & is_stat;
   assign miso      = tx[DATA_W-1];

   assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= FRM_C);
   assert_cnt_on_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(cnt) && cnt != '0) |-> $past(rise));
   assert_wr_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> $past(active));
   assert_miso_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!active) |-> !miso);
endmodule

// File: rtl/spi_ram_bridge.sv
module spi_ram_bridge #(
   parameter int ADDR_W      = 10,
   parameter int DATA_W      = 8,
   parameter int PAD_W       = 5,
   parameter int SYNC_STAGES = 2,
   parameter int STATUS_ADDR = 1023,
   parameter bit HAS_STATUS  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_sclk,
   input  logic              ser_cs_n,
   input  logic              ser_mosi,
   output logic              ser_miso,
   output logic              host_irq,
   input  logic              loc_en,
   input  logic              loc_we,
   input  logic [ADDR_W-1:0] loc_addr,
   input  logic [DATA_W-1:0] loc_wdata,
   output logic [DATA_W-1:0] loc_rdata,
   input  logic              loc_irq_set
);
   localparam int DEPTH = 1 << ADDR_W;

   if (ADDR_W < 2 || DATA_W < 2 || PAD_W < 0) begin : g_bad_width
      $error("spi_ram_bridge: width parameter out of range");
   end
   if (STATUS_ADDR < 0 || STATUS_ADDR >= DEPTH) begin : g_bad_stat
      $error("spi_ram_bridge: STATUS_ADDR outside memory");
   end

   logic sclk_s, csn_s, mosi_s;
   logic              b_en, b_we, stat_clr;
   logic [ADDR_W-1:0] b_addr;
   logic [DATA_W-1:0] b_wdata, b_rdata, stat_byte;
   logic              irq_q;

   br_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ser_sclk, ser_cs_n, ser_mosi}),
      .q     ({sclk_s, csn_s, mosi_s})
   );

   br_frame_eng #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAD_W(PAD_W),
      .STATUS_ADDR(STATUS_ADDR), .HAS_STATUS(HAS_STATUS)
   ) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .sclk_s    (sclk_s),
      .csn_s     (csn_s),
      .mosi_s    (mosi_s),
      .ram_rdata (b_rdata),
      .stat_byte (stat_byte),
      .ram_en    (b_en),
      .ram_we    (b_we),
      .ram_addr  (b_addr),
      .ram_wdata (b_wdata),
      .stat_clr  (stat_clr),
      .miso      (ser_miso)
   );

   br_dpram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
      .clk     (clk),
      .a_en    (loc_en),
      .a_we    (loc_we),
      .a_addr  (loc_addr),
      .a_wdata (loc_wdata),
      .a_rdata (loc_rdata),
      .b_en    (b_en),
      .b_we    (b_we),
      .b_addr  (b_addr),
      .b_wdata (b_wdata),
      .b_rdata (b_rdata)
   );

   if (HAS_STATUS) begin : g_irq
      // Set has priority over a coincident host clear.
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           irq_q <= 1'b0;
         else if (loc_irq_set) irq_q <= 1'b1;
         else if (stat_clr)    irq_q <= 1'b0;
      end

      assert_irq_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(irq_q) |-> $past(loc_irq_set));
      assert_irq_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(irq_q) |-> $past(stat_clr));
   end else begin : g_noirq
      logic unused_irq_in;
      assign unused_irq_in = loc_irq_set ^ stat_clr;
      assign irq_q = 1'b0;
   end

   assign stat_byte = {{(DATA_W-1){1'b0}}, irq_q};
   assign host_irq  = irq_q;
endmodule

// File: tb/spi_ram_bridge_tb.sv
module spi_ram_bridge_tb_top;
   localparam int HALF = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ser_sclk = 1'b0, ser_cs_n = 1'b1, ser_mosi = 1'b0;
   logic       ser_miso, host_irq;
   logic       loc_en = 1'b0, loc_we = 1'b0, loc_irq_set = 1'b0;
   logic [9:0] loc_addr = '0;
   logic [7:0] loc_wdata = '0, loc_rdata;
   int checks = 0, failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   spi_ram_bridge #(
      .ADDR_W(10), .DATA_W(8), .PAD_W(5), .SYNC_STAGES(2),
      .STATUS_ADDR(1023), .HAS_STATUS(1'b1)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .ser_sclk(ser_sclk), .ser_cs_n(ser_cs_n),
      .ser_mosi(ser_mosi), .ser_miso(ser_miso), .host_irq(host_irq),
      .loc_en(loc_en), .loc_we(loc_we), .loc_addr(loc_addr),
      .loc_wdata(loc_wdata), .loc_rdata(loc_rdata), .loc_irq_set(loc_irq_set)
   );

   // {read, addr[9:0], data[7:0]}
   localparam logic [18:0] VEC [6] = '{
      {1'b0, 10'h000, 8'h3C},
      {1'b0, 10'h3FE, 8'hC3},
      {1'b1, 10'h155, 8'hA5},
      {1'b1, 10'h2AA, 8'h5A},
      {1'b0, 10'h0F0, 8'hFF},
      {1'b1, 10'h001, 8'h00}
   };

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic host_frame(input logic cmd, input logic [4:0] pad, input logic [9:0] addr,
                             input logic [7:0] wdat, input int nbits, output logic [7:0] rdat);
      logic [23:0] frm;
      frm  = {cmd, pad, addr, wdat};
      rdat = '0;
      @(negedge clk);
      ser_cs_n = 1'b0;
      wait_clk(HALF);
      for (int i = 0; i < nbits; i++) begin
         ser_mosi = (i < 24) ? frm[23-i] : 1'b1;
         wait_clk(HALF);
         ser_sclk = 1'b1;
         if (i >= 16 && i < 24) rdat = {rdat[6:0], ser_miso};
         wait_clk(HALF);
         ser_sclk = 1'b0;
      end
      wait_clk(HALF);
      ser_cs_n = 1'b1;
      ser_mosi = 1'b0;
      wait_clk(10);
   endtask

   task automatic loc_write(input logic [9:0] a, input logic [7:0] d);
      @(negedge clk);
      loc_en = 1'b1; loc_we = 1'b1; loc_addr = a; loc_wdata = d;
      @(negedge clk);
      loc_en = 1'b0; loc_we = 1'b0;
   endtask

   task automatic loc_read(input logic [9:0] a, output logic [7:0] d);
      @(negedge clk);
      loc_en = 1'b1; loc_we = 1'b0; loc_addr = a;
      @(negedge clk);
      loc_en = 1'b0;
      d = loc_rdata;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [7:0] r, r2;
      wait_clk(4);
      rst_n = 1'b1;
      wait_clk(2);
      chk("R9 reset miso", {15'd0, ser_miso}, 16'd0);
      chk("R9 reset irq", {15'd0, host_irq}, 16'd0);

      // Table walk: R1 writes read back locally, R2 reads of locally written bytes
      for (int k = 0; k < 6; k++) begin
         if (VEC[k][18]) begin
            loc_write(VEC[k][17:8], VEC[k][7:0]);
            host_frame(1'b1, 5'd0, VEC[k][17:8], 8'h00, 24, r);
            chk("R2 serial read", {8'd0, r}, {8'd0, VEC[k][7:0]});
         end else begin
            host_frame(1'b0, 5'd0, VEC[k][17:8], VEC[k][7:0], 24, r);
            loc_read(VEC[k][17:8], r);
            chk("R1 serial write", {8'd0, r}, {8'd0, VEC[k][7:0]});
         end
      end

      // R9: miso back to 0 after a read ending in a 1 bit
      host_frame(1'b1, 5'd0, 10'h0F0, 8'h00, 24, r);
      chk("R2 read all ones", {8'd0, r}, 16'h00FF);
      chk("R9 miso idle", {15'd0, ser_miso}, 16'd0);

      // R3: filler bits have no effect
      host_frame(1'b0, 5'h1F, 10'h123, 8'h77, 24, r);
      host_frame(1'b1, 5'h0A, 10'h123, 8'h00, 24, r);
      chk("R3 filler ignored", {8'd0, r}, 16'h0077);

      // R4: write aborted after 23 edges
      loc_write(10'h050, 8'h11);
      host_frame(1'b0, 5'd0, 10'h050, 8'hEE, 23, r);
      loc_read(10'h050, r);
      chk("R4 aborted write", {8'd0, r}, 16'h0011);

      // R5: extra edges beyond 24 are ignored
      host_frame(1'b0, 5'd0, 10'h060, 8'h42, 30, r);
      loc_read(10'h060, r);
      chk("R5 overlong frame", {8'd0, r}, 16'h0042);

      // R6: local port active during a serial read
      loc_write(10'h080, 8'h99);
      fork
         host_frame(1'b1, 5'd0, 10'h080, 8'h00, 24, r);
         begin
            wait_clk(200);
            loc_write(10'h070, 8'h33);
            loc_read(10'h070, r2);
         end
      join
      chk("R6 local during frame", {8'd0, r2}, 16'h0033);
      chk("R6 concurrent serial read", {8'd0, r}, 16'h0099);

      // R7: attention line set and held
      @(negedge clk); loc_irq_set = 1'b1;
      @(negedge clk); loc_irq_set = 1'b0;
      chk("R7 irq set", {15'd0, host_irq}, 16'd1);
      wait_clk(20);
      chk("R7 irq held", {15'd0, host_irq}, 16'd1);

      // R10: status read aborted after 12 edges
      host_frame(1'b1, 5'd0, 10'h3FF, 8'h00, 12, r);
      chk("R10 aborted status read", {15'd0, host_irq}, 16'd1);

      // R8: status read returns state and clears it
      host_frame(1'b1, 5'd0, 10'h3FF, 8'h00, 24, r);
      chk("R8 status byte set", {8'd0, r}, 16'h0001);
      chk("R8 irq cleared", {15'd0, host_irq}, 16'd0);
      host_frame(1'b1, 5'd0, 10'h3FF, 8'h00, 24, r);
      chk("R8 status byte clear", {8'd0, r}, 16'h0000);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule